// File: doc/BRIEF.md
# DMA Request Priority Arbiter

This block decides which of seven expansion-bus DMA requesters owns the bus next. Each request line arrives with no timing relation to the bus clock, so every line passes through a synchroniser before it takes part in arbitration. A fixed priority order picks one winner. The winner sees its active-low acknowledge go low, and that acknowledge stays low until the requester drops its line or its transfer budget runs out. Channel index 4 belongs to the system board and is never acknowledged.

While a grant is active, the block raises the address-enable output, so I/O slaves stop decoding command lines. It also forces the address latch enable high. When no grant is active, the latch enable follows the host-side latch strobe. Each channel has a remaining-transfer counter that a load port writes. A transfer strobe from the bus engine counts the granted channel down. The last transfer of the budget produces a single terminal-count pulse and ends the grant. A wide-transfer flag tells the data path whether the current owner moves 16-bit words (channels 5 to 7) or bytes (channels 0 to 3).

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is held (rst_n low at a clock edge), and in the cycle after it, every dack_n bit is 1, aen is 0, tc is 0 and wide16 is 0.
- R2: Among eligible requests, the acknowledge goes to the lowest index, in the order 0, 1, 2, 3, 5, 6, 7.
- R3: A request on index 4 never pulls dack_n[4] low and never produces a grant.
- R4: A request held high from a falling clock edge lowers its dack_n bit at the third rising edge after that falling edge and not earlier: two synchroniser stages, then the grant register.
- R5: At most one dack_n bit is low at any time. A granted channel keeps its acknowledge while its request stays high and its count lasts, even when a higher-priority request arrives.
- R6: When the granted request drops, its acknowledge returns high at the third rising edge. At least one clock with no grant then follows before any new grant.
- R7: aen is 1 exactly when one dack_n bit is low.
- R8: bale is 1 whenever aen is 1. Otherwise bale equals host_ale.
- R9: wide16 is 1 while channel 5, 6 or 7 holds the grant, and 0 otherwise.
- R10: A cnt_load bit writes cnt_value into that channel's counter at the next edge. Each xfer_strobe seen at an edge during a grant lowers the granted channel's count by one. The strobe that finds a count of 1 makes tc 1 for exactly the next cycle, and at that same edge it releases the grant (dack_n all 1, aen 0).
- R11: A channel whose count is 0 is not eligible: its request is ignored and its acknowledge stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dreq_async | input | NUM_CH | Asynchronous active-high DMA requests, one per index |
| host_ale | input | 1 | Host latch strobe, passed to bale when no DMA owns the bus |
| cnt_load | input | NUM_CH | Per-channel load strobe for the transfer counter |
| cnt_value | input | CNT_W | Count written by cnt_load |
| xfer_strobe | input | 1 | One transfer of the granted channel completed |
| dack_n | output | NUM_CH | Active-low acknowledges, at most one low |
| aen | output | 1 | High while a DMA grant owns the bus |
| bale | output | 1 | Address latch enable, forced high during DMA |
| wide16 | output | 1 | Granted channel uses 16-bit transfers |
| tc | output | 1 | One-cycle terminal-count pulse |

## Verification
The case hardest to reach from the ports is a grant that ends on the terminal count while its request is still high. That channel must not be granted again, because its count is now zero. The stimulus loads a count of two, keeps the request asserted, and sends two transfer strobes. It then checks the one-cycle pulse, the release at the same edge, and that the grant stays off for several more cycles. A second hard case is a higher-priority request that arrives during a grant. The bench shows that it waits out the grant, then wins after the idle gap against a lower-priority request that was also pending.

// File: rtl/dma_arb_pkg.sv
// Shared types and helpers for the DMA request arbiter.
package dma_arb_pkg;

    // Arbiter sequencing: wait for requests, own the bus, one idle clock.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_GAP   = 2'd2
    } arb_state_e;

    // Mask of channel indices at or above wide_base (16-bit channels).
    function automatic logic [31:0] wide_mask(input int unsigned n_ch,
                                              input int unsigned wide_base);
        logic [31:0] m;
        m = '0;
        for (int unsigned i = 0; i < n_ch; i++) begin
            if (i >= wide_base) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dma_req_sync.sv
// Multi-stage synchroniser for a vector of asynchronous request lines.
// Assumes each line is held stable long enough to be seen (requesters
// hold until acknowledged). Output lags input by STAGES rising edges.
module dma_req_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stage [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw asynchronous lines.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[0] <= '0;
                    else        stage[0] <= d_async;
                end
            end else begin : g_next
                // Shift through the remaining settling stages.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[s] <= '0;
                    else        stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage[STAGES-1];

endmodule

// File: rtl/dma_prio_pick.sv
// Fixed-priority picker: the lowest eligible index wins, and the reserved
// index is skipped. Purely combinational; the output is one-hot or zero.
module dma_prio_pick #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned RSV_CH = 4
) (
    input  logic [NUM_CH-1:0] eligible,
    output logic [NUM_CH-1:0] pick
);

    logic found;

    // Scan from the highest priority (index 0) down to the lowest.
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int unsigned i = 0; i < NUM_CH; i++) begin
            if (i != RSV_CH && eligible[i] && !found) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
    end

    // R2: at most one channel picked.
    always_comb begin
        a_r2_pick_onehot: assert ($onehot0(pick));
    end

endmodule

// File: rtl/dma_ch_counter.sv
// Remaining-transfer counter for one DMA channel. A load overrides a
// decrement in the same cycle. Assumes dec is only raised while nonzero.
module dma_ch_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             nonzero,
    output logic             last_one
);

    logic [CNT_W-1:0] cnt;

    // Hold, load or count down the remaining transfers.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - 1'b1;
    end

    assign nonzero  = (cnt != '0);
    assign last_one = (cnt == CNT_W'(1));

    // R11: an empty channel is never counted down (it cannot be granted).
    a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt != '0));

endmodule

// File: rtl/dma_req_arbiter.sv
// Top of the DMA request arbiter. It synchronises the request lines,
// masks channels with no transfers left, picks a winner by fixed priority,
// holds the grant until release or terminal count, then inserts one idle
// clock. It drives the bus-ownership outputs from the registered grant.
// Assumes xfer_strobe comes from the bus engine, one pulse per transfer.
module dma_req_arbiter #(
    parameter int unsigned NUM_CH      = 8,
    parameter int unsigned RSV_CH      = 4,
    parameter int unsigned WIDE_BASE   = 5,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] dreq_async,
    input  logic              host_ale,
    input  logic [NUM_CH-1:0] cnt_load,
    input  logic [CNT_W-1:0]  cnt_value,
    input  logic              xfer_strobe,
    output logic [NUM_CH-1:0] dack_n,
    output logic              aen,
    output logic              bale,
    output logic              wide16,
    output logic              tc
);

    import dma_arb_pkg::*;

    localparam logic [31:0]       WIDE_ALL = wide_mask(NUM_CH, WIDE_BASE);
    localparam logic [NUM_CH-1:0] WIDE_SET = WIDE_ALL[NUM_CH-1:0];

    arb_state_e        state;
    logic [NUM_CH-1:0] dreq_s;
    logic [NUM_CH-1:0] cnt_nz;
    logic [NUM_CH-1:0] cnt_one;
    logic [NUM_CH-1:0] eligible;
    logic [NUM_CH-1:0] pick;
    logic [NUM_CH-1:0] gnt_q;
    logic              owning;
    logic              req_held;
    logic              tc_now;
    logic              tc_q;

    dma_req_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (dreq_async),
        .q_sync  (dreq_s)
    );

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_cnt
            dma_ch_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (cnt_load[c]),
                .load_val (cnt_value),
                .dec      (owning && xfer_strobe && gnt_q[c]),
                .nonzero  (cnt_nz[c]),
                .last_one (cnt_one[c])
            );
        end
    endgenerate

    assign eligible = dreq_s & cnt_nz;

    dma_prio_pick #(.NUM_CH(NUM_CH), .RSV_CH(RSV_CH)) u_pick (
        .eligible (eligible),
        .pick     (pick)
    );

    assign owning   = (state == ST_GRANT);
    assign req_held = |(gnt_q & dreq_s);
    assign tc_now   = owning && xfer_strobe && |(gnt_q & cnt_one);

    // Grant sequencer: pick, hold until release or terminal count, idle once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            gnt_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (|pick) begin
                        gnt_q <= pick;
                        state <= ST_GRANT;
                    end
                end
                ST_GRANT: begin
                    if (!req_held || tc_now) begin
                        gnt_q <= '0;
                        state <= ST_GAP;
                    end
                end
                default: begin
                    gnt_q <= '0;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Terminal-count pulse register, one cycle per expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) tc_q <= 1'b0;
        else        tc_q <= tc_now;
    end

    assign dack_n = ~gnt_q;
    assign aen    = owning;
    assign bale   = owning | host_ale;
    assign wide16 = |(gnt_q & WIDE_SET);
    assign tc     = tc_q;

    // R5: at most one acknowledge low.
    a_r5_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~dack_n));
    // R5: an ongoing grant never moves to another channel.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (aen && $past(aen)) |-> $stable(dack_n));
    // R3: the reserved channel is never acknowledged.
    a_r3_rsv_idle: assert property (@(posedge clk) disable iff (!rst_n)
        dack_n[RSV_CH]);
    // R7: address enable tracks the acknowledge set.
    a_r7_aen_ack: assert property (@(posedge clk) disable iff (!rst_n)
        aen == (dack_n != {NUM_CH{1'b1}}));
    // R8: latch enable forced high while DMA owns the bus.
    a_r8_bale_high: assert property (@(posedge clk) disable iff (!rst_n)
        aen |-> bale);
    // R6: an idle clock follows every grant.
    a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(aen) |=> !aen);
    // R10: terminal count is a single-cycle pulse.
    a_r10_tc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);
    // R10: terminal count coincides with the release of the grant.
    a_r10_tc_release: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> !aen);

endmodule

// File: tb/dma_req_arbiter_tb.sv
// Scoreboard bench: the driver queues expected output snapshots tagged
// with the cycle they are due in; the monitor compares them when due.
module dma_req_arbiter_tb;

    localparam int unsigned NUM_CH = 8;
    localparam int unsigned CNT_W  = 16;

    typedef struct {
        int                cyc;
        string             tag;
        logic [NUM_CH-1:0] dack;
        logic              aen;
        logic              bale;
        logic              w16;
        logic              tc;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] dreq_async = '0;
    logic              host_ale = 1'b0;
    logic [NUM_CH-1:0] cnt_load = '0;
    logic [CNT_W-1:0]  cnt_value = '0;
    logic              xfer_strobe = 1'b0;
    logic [NUM_CH-1:0] dack_n;
    logic              aen;
    logic              bale;
    logic              wide16;
    logic              tc;

    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    dma_req_arbiter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .dreq_async  (dreq_async),
        .host_ale    (host_ale),
        .cnt_load    (cnt_load),
        .cnt_value   (cnt_value),
        .xfer_strobe (xfer_strobe),
        .dack_n      (dack_n),
        .aen         (aen),
        .bale        (bale),
        .wide16      (wide16),
        .tc          (tc)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Driver side: queue the expected outputs k cycles ahead (ch = -1 idle).
    task automatic expect_at(input int k, input string tag, input int ch,
                             input logic tcv);
        exp_t e;
        e.cyc  = cyc + k;
        e.tag  = tag;
        e.dack = (ch < 0) ? {NUM_CH{1'b1}} : ~(NUM_CH'(1) << ch);
        e.aen  = (ch >= 0);
        e.bale = (ch >= 0) | host_ale;
        e.w16  = (ch >= 5);
        e.tc   = tcv;
        sb_q.push_back(e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare every expectation due in this cycle, away from edges.
    always @(negedge clk) begin
        #1;
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].cyc == cyc) begin
                n_run++;
                if (dack_n !== sb_q[i].dack || aen !== sb_q[i].aen ||
                    bale !== sb_q[i].bale || wide16 !== sb_q[i].w16 ||
                    tc !== sb_q[i].tc) begin
                    n_fail++;
                    $display("FAIL %s cyc %0d: got dack_n=%b aen=%b bale=%b wide16=%b tc=%b, exp dack_n=%b aen=%b bale=%b wide16=%b tc=%b",
                             sb_q[i].tag, cyc, dack_n, aen, bale, wide16, tc,
                             sb_q[i].dack, sb_q[i].aen, sb_q[i].bale,
                             sb_q[i].w16, sb_q[i].tc);
                end
                sb_q.delete(i);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        expect_at(0, "R1 reset state", -1, 1'b0);
        tick(1);
        host_ale = 1'b1;
        expect_at(0, "R8 bale follows host_ale", -1, 1'b0);
        tick(1);
        host_ale = 1'b0;

        // R11: zero-count channel ignored.
        dreq_async[2] = 1'b1;
        expect_at(3, "R11 empty channel idle", -1, 1'b0);
        expect_at(5, "R11 empty channel idle", -1, 1'b0);
        tick(6);
        dreq_async[2] = 1'b0;
        tick(4);

        // R10: load counts (channel 2 left empty, channel 3 gets two).
        cnt_value = 16'd4;
        cnt_load  = 8'b1111_0011;
        tick(1);
        cnt_value = 16'd2;
        cnt_load  = 8'b0000_1000;
        tick(1);
        cnt_load  = '0;
        tick(1);

        // R4 and R2: two wide requests at once, index 5 wins on edge three.
        dreq_async[7] = 1'b1;
        dreq_async[5] = 1'b1;
        expect_at(2, "R4 not before third edge", -1, 1'b0);
        expect_at(3, "R2 ch5 over ch7, R9 wide", 5, 1'b0);
        tick(4);

        // R5: higher-priority arrival does not preempt.
        dreq_async[0] = 1'b1;
        expect_at(3, "R5 hold ch5", 5, 1'b0);
        expect_at(6, "R5 hold ch5", 5, 1'b0);
        tick(7);

        // R6: release, idle gap, then ch0 beats pending ch7.
        dreq_async[5] = 1'b0;
        expect_at(3, "R6 release", -1, 1'b0);
        expect_at(4, "R6 idle gap", -1, 1'b0);
        expect_at(5, "R2 ch0 after gap, R9 narrow", 0, 1'b0);
        tick(6);

        // R3: reserved index alone never acknowledged.
        dreq_async[0] = 1'b0;
        dreq_async[7] = 1'b0;
        dreq_async[4] = 1'b1;
        expect_at(3, "R7 release before reserved test", -1, 1'b0);
        expect_at(8, "R3 reserved ignored", -1, 1'b0);
        expect_at(12, "R3 reserved ignored", -1, 1'b0);
        tick(13);
        dreq_async[4] = 1'b0;
        tick(4);

        // R10: terminal count on the second strobe with request still high.
        dreq_async[3] = 1'b1;
        expect_at(3, "R10 ch3 granted", 3, 1'b0);
        tick(4);
        xfer_strobe = 1'b1;
        tick(1);
        xfer_strobe = 1'b1;
        expect_at(0, "R10 no tc at count 2", 3, 1'b0);
        expect_at(1, "R10 tc pulse and release", -1, 1'b1);
        expect_at(2, "R10 tc single cycle", -1, 1'b0);
        expect_at(5, "R11 expired channel not regranted", -1, 1'b0);
        tick(1);
        xfer_strobe = 1'b0;
        tick(5);
        dreq_async[3] = 1'b0;
        tick(4);

        // R2: full priority walk 1 > 5 > 6 > 7 (2 empty, 3 expired).
        dreq_async = 8'b1110_0110;
        expect_at(3, "R2 ch1 first", 1, 1'b0);
        tick(4);
        dreq_async[1] = 1'b0;
        expect_at(5, "R9 ch5 wide", 5, 1'b0);
        tick(6);
        dreq_async[5] = 1'b0;
        expect_at(5, "R2 ch6 next", 6, 1'b0);
        tick(6);
        dreq_async[6] = 1'b0;
        expect_at(5, "R2 ch7 last", 7, 1'b0);
        tick(6);
        dreq_async[7] = 1'b0;
        expect_at(3, "R7 aen low when idle", -1, 1'b0);
        tick(5);

        // R1: reset in the middle of a grant.
        dreq_async[6] = 1'b1;
        tick(5);
        rst_n = 1'b0;
        tick(1);
        expect_at(0, "R1 reset clears grant", -1, 1'b0);
        rst_n = 1'b1;
        dreq_async[6] = 1'b0;
        tick(3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule